// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the processor-facing side of a four-channel DMA controller. It sits behind an 8-bit port window of sixteen offsets and holds everything software programs before a transfer starts: per-channel 16-bit start address and transfer count, a 6-bit mode per channel, a channel mask per channel, a command byte and a software request per channel. The values go straight out to the channel engines. The engines report terminal count and hardware requests back, and these are visible through a status port.

Every register is 8 bits wide on the bus. The 16-bit address and count values therefore pass through a single byte-pointer flip-flop that all channels share. The first access after the pointer is cleared reaches the low byte, the next one the high byte, and so on in alternation. Software clears the pointer before it programs a channel. A parameter builds a word-wide instance in which every offset is doubled and the lowest address bit is ignored.

Top module: `dma_regif`

## Requirements
- R1: After reset all four mask bits are 1, the command byte, request bits, status flags, addresses, counts and modes are 0, and the byte pointer selects the low byte.
- R2: For channel c, the address register is at offset 2c and the count register is at offset 2c+1. A write stores its byte into the half that the pointer selects (0 = bits [7:0], 1 = bits [15:8]).
- R3: One pointer serves all channels. Any read or write of offsets 0x0 to 0x7 toggles it, whichever channel or register is accessed.
- R4: A write of any value to offset 0xC forces the pointer to the low-byte state.
- R5: A read of offsets 0x0 to 0x7 returns the byte of the stored 16-bit value that the pointer selects, so two reads give the low byte and then the high byte.
- R6: A write to offset 0xA uses data bits [1:0] as the channel. Bit 2 = 1 sets that channel's mask bit and bit 2 = 0 clears it. The other channels are unchanged.
- R7: A write to offset 0xB stores data bits [7:2] as the mode of the channel in bits [1:0]. In mode_o, field bits [1:0] hold the direction, bit 2 autoinit, bit 3 decrement and bits [5:4] the transfer style. Data 0x44 gives a mode of 0x11, 0x48 gives 0x12 and 0xC0 gives 0x30.
- R8: A write to offset 0xF loads data bits [3:0] into the four mask bits. A write to offset 0xE clears all four mask bits.
- R9: A write to offset 0xD (master clear) sets all mask bits and clears the pointer, the command byte, the request bits and the terminal-count flags. Addresses, counts and modes are left unchanged.
- R10: A read of offset 0x8 returns the sticky terminal-count flags in bits [3:0] and the pending requests (software request OR dreq_i) in bits [7:4]. The read clears the flags. A tc_i pulse in the same cycle as the read is kept.
- R11: A write to offset 0x9 uses bits [1:0] as the channel and bit 2 as the new value of that channel's software request.
- R12: A write to offset 0x8 stores the full byte as the command value.
- R13: With WORD_MAP = 1 every offset is doubled and address bit 0 is ignored.
- R14: With cs_i low, writes and reads change no register and do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select for the port window |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe, one access per cycle |
| addr_i | input | 4+WORD_MAP | Port offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from offset and pointer |
| tc_i | input | 4 | Terminal-count pulses from the channel engines |
| dreq_i | input | 4 | Hardware request levels |
| addr_o | output | 64 | Start addresses, channel c in bits [16c+15:16c] |
| cnt_o | output | 64 | Counts (transfers minus one), channel c in bits [16c+15:16c] |
| mode_o | output | 24 | Modes, channel c in bits [6c+5:6c] |
| mask_o | output | 4 | Channel mask bits, 1 = disabled |
| cmd_o | output | 8 | Command byte |
| req_o | output | 4 | Software request bits |

## Verification
The pointer is tested with several patterns. Two accesses to the same register check low-then-high ordering. Accesses to two different channels with no clear between them show whether the pointer is really shared rather than kept per channel. A clear in the middle of a pair shows that the clear overrides the alternation. Reads mixed with writes show that reads move the pointer as well. For the mask, a sequence of set and clear writes to single channels is followed by bulk load, bulk clear and master clear, and each step leaves a bit pattern that only the correct encoding produces. A status read made after a terminal-count pulse, followed by a second read, separates the sticky flags from the live request bits.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;
  localparam int unsigned NCH  = 4;
  localparam int unsigned BW   = 8;
  localparam int unsigned RW   = 16;
  localparam int unsigned MW   = 6;
  localparam int unsigned CHW  = $clog2(NCH);

  typedef enum logic [2:0] {
    OFS_CMD    = 3'd0,
    OFS_REQ    = 3'd1,
    OFS_SMASK  = 3'd2,
    OFS_MODE   = 3'd3,
    OFS_CLRPTR = 3'd4,
    OFS_MCLR   = 3'd5,
    OFS_CLRMSK = 3'd6,
    OFS_AMASK  = 3'd7
  } ctl_ofs_e;
endpackage

// File: rtl/dma_ptr_ff.sv
module dma_ptr_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  input  logic clr_i,
  output logic hi_o
);
  logic ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= 1'b0;
    else if (clr_i) ptr_q <= 1'b0;
    else if (tgl_i) ptr_q <= ~ptr_q;
  end

  assign hi_o = ptr_q;

  // R4
  ptr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !hi_o);
  // R3
  ptr_tgl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgl_i && !clr_i) |=> (hi_o != $past(hi_o)));
  // R14
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tgl_i && !clr_i) |=> $stable(hi_o));
endmodule

// File: rtl/dma_word_reg.sv
module dma_word_reg #(
  parameter int unsigned RW = 16,
  localparam int unsigned BW = RW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          hi_i,
  input  logic [BW-1:0] wdata_i,
  output logic [RW-1:0] val_o
);
  logic [BW-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (we_i) begin
      if (hi_i) hi_q <= wdata_i;
      else      lo_q <= wdata_i;
    end
  end

  assign val_o = {hi_q, lo_q};

  // R2
  wr_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hi_i) |=> (val_o[BW-1:0] == $past(wdata_i)) && $stable(val_o[RW-1:BW]));
  // R2
  wr_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hi_i) |=> (val_o[RW-1:BW] == $past(wdata_i)) && $stable(val_o[BW-1:0]));
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_regif_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic                st_rd_i,
  input  ctl_ofs_e            ofs_i,
  input  logic [BW-1:0]       wdata_i,
  input  logic [NCH-1:0]      tc_i,
  input  logic [NCH-1:0]      dreq_i,
  output logic [NCH-1:0]      mask_o,
  output logic [NCH*MW-1:0]   mode_o,
  output logic [BW-1:0]       cmd_o,
  output logic [NCH-1:0]      req_o,
  output logic [BW-1:0]       status_o
);
  logic [NCH-1:0]     mask_q, req_q, tc_q;
  logic [BW-1:0]      cmd_q;
  logic [MW-1:0]      mode_q [NCH];
  logic [CHW-1:0]     wch;
  logic               mclr;

  assign wch  = wdata_i[CHW-1:0];
  assign mclr = we_i && (ofs_i == OFS_MCLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      req_q  <= '0;
      cmd_q  <= '0;
    end else if (mclr) begin
      mask_q <= '1;
      req_q  <= '0;
      cmd_q  <= '0;
    end else if (we_i) begin
      unique case (ofs_i)
        OFS_CMD:    cmd_q       <= wdata_i;
        OFS_REQ:    req_q[wch]  <= wdata_i[2];
        OFS_SMASK:  mask_q[wch] <= wdata_i[2];
        OFS_CLRMSK: mask_q      <= '0;
        OFS_AMASK:  mask_q      <= wdata_i[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tc_q <= '0;
    else if (mclr)    tc_q <= '0;
    else if (st_rd_i) tc_q <= tc_i;
    else              tc_q <= tc_q | tc_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mode_q[c] <= '0;
      else if (we_i && ofs_i == OFS_MODE && wch == CHW'(c))
        mode_q[c] <= wdata_i[BW-1:BW-MW];
    end
    assign mode_o[c*MW +: MW] = mode_q[c];
  end

  assign mask_o   = mask_q;
  assign cmd_o    = cmd_q;
  assign req_o    = req_q;
  assign status_o = {req_q | dreq_i, tc_q};

  // R9
  mclr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr |=> (mask_o == '1) && (cmd_o == '0) && (req_o == '0) && (status_o[NCH-1:0] == '0));
  // R8
  clr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ofs_i == OFS_CLRMSK) |=> (mask_o == '0));
  // R10
  st_rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_rd_i && tc_i == '0) |=> (status_o[NCH-1:0] == '0));
  // R10
  tc_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_rd_i && !mclr) |=> ((status_o[NCH-1:0] & $past(status_o[NCH-1:0])) == $past(status_o[NCH-1:0])));
endmodule

// File: rtl/dma_regif.sv
module dma_regif
  import dma_regif_pkg::*;
#(
  parameter int unsigned WORD_MAP = 0,
  localparam int unsigned AW = 4 + WORD_MAP
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [BW-1:0]       wdata_i,
  output logic [BW-1:0]       rdata_o,
  input  logic [NCH-1:0]      tc_i,
  input  logic [NCH-1:0]      dreq_i,
  output logic [NCH*RW-1:0]   addr_o,
  output logic [NCH*RW-1:0]   cnt_o,
  output logic [NCH*MW-1:0]   mode_o,
  output logic [NCH-1:0]      mask_o,
  output logic [BW-1:0]       cmd_o,
  output logic [NCH-1:0]      req_o
);
  logic [3:0]     ofs;
  logic           wr, rd, chan_acc, ctl_acc, ptr_hi, ptr_clr;
  logic [CHW-1:0] sel_ch;
  logic           sel_cnt;
  logic [BW-1:0]  status;
  logic [RW-1:0]  rd_word;
  ctl_ofs_e       ctl_ofs;

  // word-wide instance drops address bit 0
  if (WORD_MAP != 0) begin : g_word
    assign ofs = addr_i[AW-1:WORD_MAP];
  end else begin : g_byte
    assign ofs = addr_i;
  end

  assign wr       = cs_i && wr_i;
  assign rd       = cs_i && rd_i && !wr_i;
  assign chan_acc = !ofs[3];
  assign ctl_acc  = ofs[3];
  assign sel_ch   = ofs[2:1];
  assign sel_cnt  = ofs[0];
  assign ctl_ofs  = ctl_ofs_e'(ofs[2:0]);
  assign ptr_clr  = wr && ctl_acc && (ctl_ofs == OFS_CLRPTR || ctl_ofs == OFS_MCLR);

  dma_ptr_ff u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tgl_i  ((wr || rd) && chan_acc),
    .clr_i  (ptr_clr),
    .hi_o   (ptr_hi)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_word_reg #(.RW(RW)) u_addr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr && chan_acc && sel_ch == CHW'(c) && !sel_cnt),
      .hi_i    (ptr_hi),
      .wdata_i (wdata_i),
      .val_o   (addr_o[c*RW +: RW])
    );
    dma_word_reg #(.RW(RW)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr && chan_acc && sel_ch == CHW'(c) && sel_cnt),
      .hi_i    (ptr_hi),
      .wdata_i (wdata_i),
      .val_o   (cnt_o[c*RW +: RW])
    );
  end

  dma_ctl_regs u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr && ctl_acc),
    .st_rd_i  (rd && ctl_acc && ctl_ofs == OFS_CMD),
    .ofs_i    (ctl_ofs),
    .wdata_i  (wdata_i),
    .tc_i     (tc_i),
    .dreq_i   (dreq_i),
    .mask_o   (mask_o),
    .mode_o   (mode_o),
    .cmd_o    (cmd_o),
    .req_o    (req_o),
    .status_o (status)
  );

  assign rd_word = sel_cnt ? cnt_o[sel_ch*RW +: RW] : addr_o[sel_ch*RW +: RW];

  always_comb begin
    rdata_o = '0;
    if (cs_i && rd_i) begin
      if (chan_acc)                    rdata_o = ptr_hi ? rd_word[RW-1:BW] : rd_word[BW-1:0];
      else if (ctl_ofs == OFS_CMD)     rdata_o = status;
    end
  end

  // R14
  no_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> $stable(addr_o) && $stable(cnt_o) && $stable(mask_o) && $stable(cmd_o) && $stable(req_o) && $stable(mode_o));
  // R6
  smask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && ctl_acc && ctl_ofs == OFS_SMASK) |=> (mask_o[$past(wdata_i[CHW-1:0])] == $past(wdata_i[2])));
endmodule

// File: tb/sim_dma_regif.sv
module sim_dma_regif;
  logic clk = 0, rst_n = 0;
  logic cs = 0, wr = 0, rd = 0;
  logic [3:0] addr = 0;
  logic [4:0] addr1 = 0;
  logic cs1 = 0;
  logic [7:0] wdata = 0, rdata, rdata1;
  logic [3:0] tc = 0, dreq = 0;
  logic [63:0] addr_o, cnt_o, addr1_o, cnt1_o;
  logic [23:0] mode_o, mode1_o;
  logic [3:0] mask_o, mask1_o, req_o, req1_o;
  logic [7:0] cmd_o, cmd1_o;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  dma_regif u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tc_i(tc), .dreq_i(dreq), .addr_o(addr_o),
    .cnt_o(cnt_o), .mode_o(mode_o), .mask_o(mask_o), .cmd_o(cmd_o), .req_o(req_o));

  dma_regif #(.WORD_MAP(1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs1), .wr_i(wr), .rd_i(1'b0), .addr_i(addr1),
    .wdata_i(wdata), .rdata_o(rdata1), .tc_i(4'b0), .dreq_i(4'b0), .addr_o(addr1_o),
    .cnt_o(cnt1_o), .mode_o(mode1_o), .mask_o(mask1_o), .cmd_o(cmd1_o), .req_o(req1_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic wr_word(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); cs1 = 1; wr = 1; addr1 = a; wdata = d;
    @(negedge clk); cs1 = 0; wr = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 mask", mask_o, 4'hF);
    chk("R1 cmd", cmd_o, 0);
    chk("R1 req", req_o, 0);
    chk("R1 addr", addr_o, 0);
    chk("R1 mode", mode_o, 0);
    wr_reg(4'h0, 8'h5A);
    chk("R1 ptr low", addr_o[15:0], 16'h005A);
    wr_reg(4'hC, 8'h00);
    wr_reg(4'h0, 8'h00);
  endtask

  task automatic t_map;
    wr_reg(4'hC, 0);
    wr_reg(4'h4, 8'h34); wr_reg(4'h4, 8'h12);
    chk("R2 addr ch2", addr_o[47:32], 16'h1234);
    wr_reg(4'h5, 8'hFF); wr_reg(4'h5, 8'h01);
    chk("R2 cnt ch2", cnt_o[47:32], 16'h01FF);
    chk("R2 others", {addr_o[31:0], cnt_o[31:0]}, 0);
  endtask

  task automatic t_shared;
    wr_reg(4'hC, 0);
    wr_reg(4'h0, 8'hAA);
    wr_reg(4'h3, 8'hBB);
    chk("R3 shared ptr", cnt_o[31:16], 16'hBB00);
    wr_reg(4'h3, 8'hCC);
    chk("R3 wrap", cnt_o[31:16], 16'hBBCC);
  endtask

  task automatic t_clrptr;
    wr_reg(4'hC, 0);
    wr_reg(4'h0, 8'h11);
    wr_reg(4'hC, 8'h9E);
    wr_reg(4'h0, 8'h22);
    chk("R4 clear ptr", addr_o[15:0], 16'h0022);
  endtask

  task automatic t_read;
    logic [7:0] b;
    wr_reg(4'hC, 0);
    rd_reg(4'h4, b); chk("R5 lo", b, 8'h34);
    rd_reg(4'h4, b); chk("R5 hi", b, 8'h12);
    rd_reg(4'h5, b); chk("R5 cnt lo", b, 8'hFF);
    wr_reg(4'h0, 8'h77);
    chk("R5 read moves ptr", addr_o[15:0], 16'h7722);
  endtask

  task automatic t_smask;
    wr_reg(4'hA, 8'h01); chk("R6 unmask ch1", mask_o, 4'hD);
    wr_reg(4'hA, 8'h02); chk("R6 unmask ch2", mask_o, 4'h9);
    wr_reg(4'hA, 8'h05); chk("R6 mask ch1", mask_o, 4'hB);
  endtask

  task automatic t_mode;
    wr_reg(4'hB, 8'h47); chk("R7 ch3", mode_o[23:18], 6'h11);
    wr_reg(4'hB, 8'h49); chk("R7 ch1", mode_o[11:6], 6'h12);
    wr_reg(4'hB, 8'hC0); chk("R7 ch0", mode_o[5:0], 6'h30);
    chk("R7 ch2 kept", mode_o[17:12], 6'h00);
  endtask

  task automatic t_amask;
    wr_reg(4'hF, 8'hF5); chk("R8 all mask", mask_o, 4'h5);
    wr_reg(4'hE, 8'h00); chk("R8 clear mask", mask_o, 4'h0);
  endtask

  task automatic t_req_cmd;
    wr_reg(4'h9, 8'h06); chk("R11 set ch2", req_o, 4'h4);
    wr_reg(4'h9, 8'h05); chk("R11 set ch1", req_o, 4'h6);
    wr_reg(4'h9, 8'h02); chk("R11 clr ch2", req_o, 4'h2);
    wr_reg(4'h9, 8'h06);
    wr_reg(4'h8, 8'hA5); chk("R12 cmd", cmd_o, 8'hA5);
  endtask

  task automatic t_status;
    logic [7:0] b;
    dreq = 4'b0001;
    @(negedge clk); tc = 4'b1001;
    @(negedge clk); tc = 0;
    rd_reg(4'h8, b); chk("R10 status", b, 8'h79);
    rd_reg(4'h8, b); chk("R10 cleared", b, 8'h70);
    dreq = 0;
  endtask

  task automatic t_mclr;
    logic [7:0] b;
    @(negedge clk); tc = 4'b0010;
    @(negedge clk); tc = 0;
    wr_reg(4'hC, 0);
    wr_reg(4'h2, 8'h44);
    wr_reg(4'hD, 8'h00);
    chk("R9 mask", mask_o, 4'hF);
    chk("R9 cmd", cmd_o, 0);
    chk("R9 req", req_o, 0);
    chk("R9 mode kept", mode_o[5:0], 6'h30);
    rd_reg(4'h8, b); chk("R9 status", b, 8'h00);
    wr_reg(4'h2, 8'h66);
    chk("R9 ptr", addr_o[31:16], 16'h0066);
  endtask

  task automatic t_nocs;
    @(negedge clk); cs = 0; wr = 1; addr = 4'h8; wdata = 8'hFF;
    @(negedge clk); addr = 4'h2; wdata = 8'h99;
    @(negedge clk); wr = 0;
    chk("R14 cmd", cmd_o, 0);
    chk("R14 addr", addr_o[31:16], 16'h0066);
    wr_reg(4'h2, 8'h88);
    chk("R14 ptr kept", addr_o[31:16], 16'h8866);
  endtask

  task automatic t_word;
    wr_word(5'h18, 0);
    wr_word(5'h0A, 8'h78); wr_word(5'h0B, 8'h56);
    chk("R13 cnt ch2", cnt1_o[47:32], 16'h5678);
    wr_word(5'h1C, 0);
    chk("R13 clear mask", mask1_o, 4'h0);
    chk("R13 byte inst", cnt_o[47:32], 16'h01FF);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset; t_map; t_shared; t_clrptr; t_read; t_smask; t_mode;
        t_amask; t_req_cmd; t_status; t_mclr; t_nocs; t_word;
      end
      begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule